// File: doc/BRIEF.md
# Negacyclic NTT Polynomial Multiplier

The engine computes the product of two polynomials of degree below N, with coefficients reduced modulo a prime Q and the product folded modulo x^N + 1. Coefficients go in one at a time through a load port. A start pulse runs the whole multiplication. Each coefficient of the result is then read back through a read port. The default build uses N = 256 and Q = 7681 with 16-bit coefficients.

Internally the engine keeps both operands in one single-port coefficient RAM. It scales every coefficient i by phi^i, where phi is a primitive 2N-th root of unity, and transforms both operands with decimation-in-frequency (Gentleman-Sande) butterflies. It multiplies the two spectra point by point into the first operand's storage. It then runs the same butterfly network with inverse twiddles and scales by phi^-i · N^-1. Coefficients are stored at bit-reversed addresses. Because of this, the forward transforms leave their spectra in natural order, and the inverse transform works on that data directly, with no reordering pass.

All root powers are computed when the design is elaborated, from N and Q alone. A small FSM sequences the run. It issues one RAM access per cycle, and a butterfly takes four cycles.

Top module: `ntt_polymul`

## Requirements
- R1: While busy is low, a cycle with ld_en high stores ld_data as coefficient ld_idx of operand A (ld_sel = 0) or operand B (ld_sel = 1). Loaded values must be below Q, and both operands must be reloaded before every start.
- R2: A start seen while busy is low begins a run, and busy is high in the following cycle.
- R3: After done, presenting rd_idx while idle with ld_en low shows on rd_data, one cycle later, coefficient rd_idx of a·b mod (x^N + 1), each value in [0, Q).
- R4: The product wraps negacyclically: a term x^k with k ≥ N contributes −x^(k−N), so x^1 · x^(N−1) yields Q−1 at index 0 and zero elsewhere.
- R5: busy stays high for exactly 9N + 6N·log2(N) cycles per run.
- R6: done is a single-cycle pulse. It is high in the first cycle with busy low after a run and at no other time.
- R7: A start pulse while busy is high has no effect on the running computation or its length.
- R8: ld_en while busy is high changes no stored coefficient, and the product of the run in progress is unaffected.
- R9: Every value the engine writes into its coefficient RAM during a run is below Q.
- R10: During and right after reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for one coefficient |
| ld_sel | input | 1 | Operand select: 0 = A, 1 = B |
| ld_idx | input | log2(N) | Coefficient index to load |
| ld_data | input | W | Coefficient value, below Q |
| rd_idx | input | log2(N) | Product coefficient index to read |
| rd_data | output | W | Product coefficient, one cycle after rd_idx |
| start | input | 1 | Starts a multiplication when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the engine with N = 32 and Q = 7681. A run then takes about 1250 cycles, so many full multiplications fit, and the result is compared against a schoolbook negacyclic product computed in the bench. At this size the butterfly network still has five stages. Every twiddle and both weighting tables are used, and single-monomial operands reach the wraparound term and the Q−1 boundary directly. Runs disturbed by stray start and load strobes show whether the busy window and the stored operands are protected.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_WR,
    S_BF_RX, S_BF_RY, S_BF_WX, S_BF_WY,
    S_PW_RA, S_PW_RB, S_PW_WR,
    S_POST_RD, S_POST_WR
  } ntt_state_e;

  // modular exponentiation, square and multiply over 64 exponent bits
  function automatic longint unsigned pow_mod(input longint unsigned base,
                                              input longint unsigned expo,
                                              input longint unsigned m);
    longint unsigned r, b;
    r = 1;
    b = base % m;
    for (int k = 0; k < 64; k++) begin
      if (expo[k]) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  // first primitive 2n-th root of unity mod q (q prime, 2n divides q-1)
  function automatic longint unsigned find_root2n(input longint unsigned q,
                                                  input longint unsigned n);
    longint unsigned c;
    for (longint unsigned g = 2; g < q; g++) begin
      c = pow_mod(g, (q - 1) / (2 * n), q);
      if (pow_mod(c, n, q) == q - 1) return c;
    end
    return 0;
  endfunction

endpackage

// File: rtl/ntt_modmul.sv
module ntt_modmul #(
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  localparam int QB = $clog2(Q);
  localparam int K  = 2 * QB;
  localparam longint unsigned MU = (64'd1 << K) / Q;
  localparam int XW = 3 * QB + 2;
  localparam int TW = XW - K;
  localparam int RW = QB + 3;
  localparam logic [RW-1:0] QR = RW'(Q);

  logic [2*W-1:0] prod;
  logic [XW-1:0]  scaled;
  logic [TW-1:0]  quot;
  logic [RW-1:0]  r0, r1, r2;

  always_comb begin
    prod   = a * b;
    scaled = XW'(prod) * XW'(MU);
    quot   = scaled[XW-1:K];
    r0     = RW'(prod) - (RW'(quot) * QR);
    r1     = (r0 >= QR) ? r0 - QR : r0;
    r2     = (r1 >= QR) ? r1 - QR : r1;
    p      = W'(r2);
  end
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly #(
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] tw,
  output logic [W-1:0] sum,
  output logic [W-1:0] dif_tw
);
  localparam logic [W:0] QE = (W+1)'(Q);

  logic [W:0]   s_raw;
  logic [W:0]   d_raw;
  logic [W-1:0] d_red;

  always_comb begin
    s_raw = {1'b0, x} + {1'b0, y};
    sum   = (s_raw >= QE) ? W'(s_raw - QE) : W'(s_raw);
    if (x >= y) d_raw = {1'b0, x} - {1'b0, y};
    else        d_raw = {1'b0, x} + QE - {1'b0, y};
    d_red = W'(d_raw);
  end

  ntt_modmul #(.Q(Q), .W(W)) u_mul (.a(d_red), .b(tw), .p(dif_tw));
endmodule

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
  parameter int unsigned N = 256,
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 16,
  localparam int LOGN = $clog2(N)
) (
  input  logic [1:0]      sel,   // 0 fwd twiddle, 1 inv twiddle, 2 pre weight, 3 post weight
  input  logic [LOGN-1:0] idx,
  output logic [W-1:0]    val
);
  localparam longint unsigned PHI  = ntt_pkg::find_root2n(Q, N);
  localparam longint unsigned WR   = (PHI * PHI) % Q;
  localparam longint unsigned NINV = ntt_pkg::pow_mod(N, Q - 2, Q);

  logic [W-1:0] fw_tbl  [N/2];
  logic [W-1:0] iv_tbl  [N/2];
  logic [W-1:0] pre_tbl [N];
  logic [W-1:0] pst_tbl [N];

  for (genvar g = 0; g < N / 2; g++) begin : g_tw
    localparam longint unsigned FV = ntt_pkg::pow_mod(WR, g, Q);
    localparam longint unsigned IV = ntt_pkg::pow_mod(WR, N - g, Q);
    assign fw_tbl[g] = W'(FV);
    assign iv_tbl[g] = W'(IV);
  end

  for (genvar g = 0; g < N; g++) begin : g_wt
    localparam longint unsigned PV = ntt_pkg::pow_mod(PHI, g, Q);
    localparam longint unsigned QV =
      (ntt_pkg::pow_mod(PHI, 2 * N - g, Q) * NINV) % Q;
    assign pre_tbl[g] = W'(PV);
    assign pst_tbl[g] = W'(QV);
  end

  always_comb begin
    unique case (sel)
      2'd0:    val = fw_tbl[idx[LOGN-2:0]];
      2'd1:    val = iv_tbl[idx[LOGN-2:0]];
      2'd2:    val = pre_tbl[idx];
      default: val = pst_tbl[idx];
    endcase
  end
endmodule

// File: rtl/ntt_coef_ram.sv
module ntt_coef_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ntt_polymul.sv
module ntt_polymul #(
  parameter int unsigned N = 256,
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 16,
  localparam int LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [LOGN-1:0] ld_idx,
  input  logic [W-1:0]    ld_data,
  input  logic [LOGN-1:0] rd_idx,
  output logic [W-1:0]    rd_data,
  input  logic            start,
  output logic            busy,
  output logic            done
);
  import ntt_pkg::*;

  localparam int AW = LOGN + 1;
  localparam int CW = LOGN + 1;
  localparam int SW = $clog2(LOGN) + 1;

  function automatic logic [LOGN-1:0] brev(input logic [LOGN-1:0] v);
    logic [LOGN-1:0] o;
    for (int k = 0; k < LOGN; k++) o[k] = v[LOGN-1-k];
    return o;
  endfunction

  // reset: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  ntt_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [SW-1:0]  stage_q, stage_d;
  logic [1:0]     pass_q, pass_d;     // 0 fwd A, 1 fwd B, 2 inverse on A
  logic [W-1:0]   x_q, x_d, z_q, z_d;
  logic           busy_q, busy_d, done_q, done_d;
  logic           cnt_en, x_en, z_en;

  logic           ram_we;
  logic [AW-1:0]  ram_addr;
  logic [W-1:0]   ram_wdata, ram_rdata;
  logic [1:0]     rom_sel;
  logic [LOGN-1:0] rom_idx;
  logic [W-1:0]   rom_val;
  logic [W-1:0]   mm_a, mm_b, mm_p;
  logic [W-1:0]   bf_sum, bf_z;

  // butterfly index decode
  logic [LOGN-1:0] b_idx, b_len, b_mask, b_j, b_lo, b_hi, b_e;
  logic [LOGN-1:0] map_lo, map_hi;
  logic            poly_bit;

  always_comb begin
    b_idx  = {1'b0, cnt_q[LOGN-2:0]};
    b_len  = LOGN'(N / 2) >> stage_q;
    b_mask = b_len - LOGN'(1);
    b_j    = b_idx & b_mask;
    b_lo   = ((b_idx & ~b_mask) << 1) | b_j;
    b_hi   = b_lo | b_len;
    b_e    = b_j << stage_q;
    map_lo = (pass_q == 2'd2) ? b_lo : brev(b_lo);
    map_hi = (pass_q == 2'd2) ? b_hi : brev(b_hi);
    poly_bit = (pass_q == 2'd1);
  end

  // datapath steering
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = {1'b0, brev(rd_idx)};
    ram_wdata = ld_data;
    rom_sel   = 2'd2;
    rom_idx   = cnt_q[LOGN-1:0];
    mm_a      = ram_rdata;
    mm_b      = rom_val;
    unique case (state_q)
      S_IDLE: begin
        if (ld_en) begin
          ram_we   = 1'b1;
          ram_addr = {ld_sel, brev(ld_idx)};
        end
      end
      S_PRE_RD: ram_addr = {cnt_q[LOGN], brev(cnt_q[LOGN-1:0])};
      S_PRE_WR: begin
        ram_addr  = {cnt_q[LOGN], brev(cnt_q[LOGN-1:0])};
        ram_we    = 1'b1;
        ram_wdata = mm_p;
      end
      S_BF_RX, S_BF_RY, S_BF_WX, S_BF_WY: begin
        rom_sel = (pass_q == 2'd2) ? 2'd1 : 2'd0;
        rom_idx = b_e;
        ram_addr = (state_q == S_BF_RX || state_q == S_BF_WX) ?
                   {poly_bit, map_lo} : {poly_bit, map_hi};
        if (state_q == S_BF_WX) begin
          ram_we    = 1'b1;
          ram_wdata = bf_sum;
        end else if (state_q == S_BF_WY) begin
          ram_we    = 1'b1;
          ram_wdata = z_q;
        end
      end
      S_PW_RA, S_PW_WR: begin
        ram_addr = {1'b0, cnt_q[LOGN-1:0]};
        mm_a     = x_q;
        mm_b     = ram_rdata;
        if (state_q == S_PW_WR) begin
          ram_we    = 1'b1;
          ram_wdata = mm_p;
        end
      end
      S_PW_RB: ram_addr = {1'b1, cnt_q[LOGN-1:0]};
      S_POST_RD, S_POST_WR: begin
        rom_sel  = 2'd3;
        ram_addr = {1'b0, brev(cnt_q[LOGN-1:0])};
        if (state_q == S_POST_WR) begin
          ram_we    = 1'b1;
          ram_wdata = mm_p;
        end
      end
      default: ;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stage_d = stage_q;
    pass_d  = pass_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_en  = 1'b0;
    x_en    = 1'b0;
    z_en    = 1'b0;
    x_d     = ram_rdata;
    z_d     = bf_z;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_PRE_RD;
        cnt_d   = '0;
        cnt_en  = 1'b1;
        stage_d = '0;
        pass_d  = 2'd0;
        busy_d  = 1'b1;
      end
      S_PRE_RD: state_d = S_PRE_WR;
      S_PRE_WR: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(2 * N - 1)) begin
          cnt_d   = '0;
          state_d = S_BF_RX;
        end else begin
          cnt_d   = cnt_q + CW'(1);
          state_d = S_PRE_RD;
        end
      end
      S_BF_RX: state_d = S_BF_RY;
      S_BF_RY: begin
        x_en    = 1'b1;
        state_d = S_BF_WX;
      end
      S_BF_WX: begin
        z_en    = 1'b1;
        state_d = S_BF_WY;
      end
      S_BF_WY: begin
        cnt_en  = 1'b1;
        state_d = S_BF_RX;
        if (cnt_q != CW'(N / 2 - 1)) begin
          cnt_d = cnt_q + CW'(1);
        end else begin
          cnt_d = '0;
          if (stage_q != SW'(LOGN - 1)) begin
            stage_d = stage_q + SW'(1);
          end else begin
            stage_d = '0;
            unique case (pass_q)
              2'd0:    pass_d = 2'd1;
              2'd1:    state_d = S_PW_RA;
              default: state_d = S_POST_RD;
            endcase
          end
        end
      end
      S_PW_RA: state_d = S_PW_RB;
      S_PW_RB: begin
        x_en    = 1'b1;
        state_d = S_PW_WR;
      end
      S_PW_WR: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(N - 1)) begin
          cnt_d   = '0;
          pass_d  = 2'd2;
          state_d = S_BF_RX;
        end else begin
          cnt_d   = cnt_q + CW'(1);
          state_d = S_PW_RA;
        end
      end
      S_POST_RD: state_d = S_POST_WR;
      S_POST_WR: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(N - 1)) begin
          cnt_d   = '0;
          state_d = S_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end else begin
          cnt_d   = cnt_q + CW'(1);
          state_d = S_POST_RD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      stage_q <= '0;
      pass_q  <= '0;
      x_q     <= '0;
      z_q     <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      pass_q  <= pass_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (x_en)   x_q   <= x_d;
      if (z_en)   z_q   <= z_d;
    end
  end

  ntt_coef_ram #(.DEPTH(2 * N), .W(W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  ntt_twiddle_rom #(.N(N), .Q(Q), .W(W)) u_rom (
    .sel(rom_sel), .idx(rom_idx), .val(rom_val)
  );

  ntt_modmul #(.Q(Q), .W(W)) u_wmul (.a(mm_a), .b(mm_b), .p(mm_p));

  ntt_butterfly #(.Q(Q), .W(W)) u_bf (
    .x(x_q), .y(ram_rdata), .tw(rom_val), .sum(bf_sum), .dif_tw(bf_z)
  );

  assign rd_data = ram_rdata;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/ntt_polymul_chk.sv
module ntt_polymul_chk #(
  parameter int unsigned N = 256,
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_s,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         ram_we,
  input logic [W-1:0] ram_wdata
);
  localparam int LOGN = $clog2(N);
  localparam int unsigned RUN = 9 * N + 6 * N * LOGN;

  int unsigned run_cnt;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)                 run_cnt <= 0;
    else if (start && !busy)    run_cnt <= 0;
    else if (busy)              run_cnt <= run_cnt + 1;
  end

  p_start_to_busy_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (start && !busy) |=> busy);
  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> $past(start));
  p_run_length_r5: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (run_cnt == RUN));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  p_done_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!busy && $past(busy)));
  p_coef_range_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && ram_we) |-> (ram_wdata < W'(Q)));
endmodule

bind ntt_polymul ntt_polymul_chk #(.N(N), .Q(Q), .W(W)) u_chk (
  .clk(clk), .rst_s(rst_s), .start(start), .busy(busy), .done(done),
  .ram_we(ram_we), .ram_wdata(ram_wdata)
);

// File: tb/ntt_polymul_tb.sv
module ntt_polymul_tb_top;
  localparam int N = 32;
  localparam int Q = 7681;
  localparam int W = 16;
  localparam int LOGN = $clog2(N);
  localparam int RUN = 9 * N + 6 * N * LOGN;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [LOGN-1:0] ld_idx = '0, rd_idx = '0;
  logic [W-1:0]    ld_data = '0;
  logic [W-1:0]    rd_data;
  logic            busy, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit model_on = 1'b0;
  int a_v [N];
  int b_v [N];
  int c_ref [N];

  // behavioural busy/done model
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_rem = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ntt_polymul #(.N(N), .Q(Q), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data), .start(start),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!model_on) begin
      m_busy = 1'b0; m_done = 1'b0; m_rem = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (m_rem == 1) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end
        m_rem--;
      end else if (start) begin
        m_busy = 1'b1;
        m_rem  = RUN;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(busy == m_busy, "R5 busy window", int'(busy), int'(m_busy));
      chk(done == m_done, "R6 done pulse", int'(done), int'(m_done));
    end
  end

  function automatic void ref_mul();
    for (int k = 0; k < N; k++) c_ref[k] = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint t = (longint'(a_v[i]) * b_v[j]) % Q;
        int k = i + j;
        if (k < N) c_ref[k] = int'((c_ref[k] + t) % Q);
        else       c_ref[k-N] = int'((c_ref[k-N] + Q - t) % Q);
      end
  endfunction

  task automatic load_all();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < N; i++) begin
        ld_en = 1'b1; ld_sel = p[0]; ld_idx = LOGN'(i);
        ld_data = W'((p == 0) ? a_v[i] : b_v[i]);
        @(negedge clk);
      end
    ld_en = 1'b0;
  endtask

  // disturb: 1 = stray start mid-run, 2 = stray loads mid-run
  task automatic run(input int disturb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    if (disturb == 1) begin
      start = 1'b1;               // R7
      @(negedge clk);
      start = 1'b0;
    end else if (disturb == 2) begin
      for (int i = 0; i < 8; i++) begin   // R8
        ld_en = 1'b1; ld_sel = i[0]; ld_idx = LOGN'(i * 3); ld_data = W'(1234);
        @(negedge clk);
      end
      ld_en = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_check(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx = LOGN'(i);
      @(negedge clk);
      chk(int'(rd_data) == c_ref[i], req, int'(rd_data), c_ref[i]);
    end
  endtask

  task automatic case_run(input string req, input int disturb);
    ref_mul();
    load_all();
    run(disturb);
    read_check(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R10 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    model_on = 1'b1;

    // zero operands
    for (int i = 0; i < N; i++) begin a_v[i] = 0; b_v[i] = $urandom % Q; end
    case_run("R3 zero operand", 0);

    // identity: a = 1, exercises R1 load placement for both operands
    for (int i = 0; i < N; i++) begin a_v[i] = (i == 0); b_v[i] = $urandom % Q; end
    case_run("R1 identity product", 0);

    // wraparound: x^1 * x^(N-1) = -1
    for (int i = 0; i < N; i++) begin a_v[i] = (i == 1); b_v[i] = (i == N - 1); end
    case_run("R4 negacyclic wrap", 0);

    // wraparound with higher monomials: x^(N-3) * x^5 = -x^2
    for (int i = 0; i < N; i++) begin a_v[i] = (i == N - 3) ? 7 : 0; b_v[i] = (i == 5) ? 11 : 0; end
    case_run("R4 shifted wrap", 0);

    // maximal coefficients
    for (int i = 0; i < N; i++) begin a_v[i] = Q - 1; b_v[i] = Q - 1; end
    case_run("R3 all Q-1", 0);

    // random operands
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < N; i++) begin a_v[i] = $urandom % Q; b_v[i] = $urandom % Q; end
      case_run("R3 random product", 0);
    end

    // stray start during a run
    for (int i = 0; i < N; i++) begin a_v[i] = $urandom % Q; b_v[i] = $urandom % Q; end
    case_run("R7 start while busy", 1);

    // stray loads during a run
    for (int i = 0; i < N; i++) begin a_v[i] = $urandom % Q; b_v[i] = $urandom % Q; end
    case_run("R8 load while busy", 2);

    // R2: start pulse raises busy in the next cycle
    load_all();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R6 idle after done", int'(busy), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule